// File: doc/BRIEF.md
# PCM Sample Formatter with Sample FIFO

This block sits between a register bus and a serial audio frame transmitter. Software or a DMA engine writes 32-bit words into a data register. Each word is turned into an audio sample as it is written: its bytes are put in order, the valid bits are picked out, and the sample is left-aligned. The result is stored in a small FIFO. The transmitter takes one left-aligned sample per request. If it asks while the FIFO is empty, it gets a zero (null) sample and an underrun is recorded.

A configuration register sets the sample format and the operating mode:
- bytes per sample, 1 to 4;
- valid bits per sample;
- byte order;
- justification of the valid bits;
- a chunk threshold;
- mono or dual-channel alternation.

A status vector reports the FIFO level and error conditions. Its live bits are ready, empty, full, chunk request and per-channel ready. Its sticky bits are underrun, overflow and per-channel underrun. Set-mask and clear-mask writes build an interrupt mask, and the interrupt output is the OR of the masked status. A command register can empty the FIFO or return the whole block to its reset state.

Register word addresses: 0 command (write bit 0 = flush, bit 1 = soft reset), 1 configuration (read/write), 2 sample data (write), 3 mask set (write), 4 mask clear (write), 5 mask (read), 6 status (read; a read strobe clears the sticky bits).

Configuration layout:

| Bits | Field |
|------|-------|
| [1:0] | bytes per sample minus one |
| [7:2] | valid bits per sample |
| [8] | 1 = big-endian |
| [9] | 1 = MSB-justified |
| [13:10] | chunk threshold |
| [14] | 1 = dual-channel |

Top module: `pcm_sample_packer`

## Requirements
- R1: After reset, status (address 6) reads 0x10B and configuration reads 0x483 (4 bytes, 32 valid bits, little-endian, LSB-justified, chunk threshold 1, mono). The mask reads 0 and irq is 0. Status bit meanings: 0 ready, 1 empty, 2 full, 3 chunk, 4 underrun, 5 overflow, 8 and 9 channel 0 and 1 ready, 11 and 12 channel 0 and 1 underrun.
- R2: Each accepted data word leaves the FIFO in write order, one per cycle in which smp_req is high. smp_vld is high for exactly the single cycle after that request, and smp_data carries the sample in that cycle.
- R3: A data write while the FIFO holds DEPTH entries is dropped. It sets the sticky overflow bit 5. Full (bit 2) is high and ready (bit 0) is low whenever DEPTH entries are held.
- R4: A request while the FIFO is empty returns smp_data = 0. It sets sticky underrun bit 4 and bit 11 + the channel being served.
- R5: A status read with rd_en high clears the sticky bits 4, 5, 11 and 12. An event in the same cycle as that read still leaves its bit set.
- R6: When N bytes per sample are configured, only the low N bytes of a written word are used. Little-endian keeps their order. Big-endian reverses the order of those N bytes, so byte N-1 becomes the least significant.
- R7: The output holds V valid bits at bits [31:32-V], with all lower bits zero. LSB-justified takes the valid bits from bits [V-1:0] of the ordered sample. MSB-justified takes them from bits [8N-1:8N-V]. A valid-bit field of 0 or above 32 is treated as 32.
- R8: Chunk bit 3 is high exactly when the number of free FIFO entries is at least the chunk threshold.
- R9: In dual mode, accepted writes alternate channels starting at channel 0. Bit 8+c is high when the next write goes to channel c and the FIFO is not full. Requests alternate smp_ch starting at 0. In mono mode, bit 9 and smp_ch stay 0.
- R10: Writes to address 3 OR bits into the mask, and writes to address 4 clear them. irq equals the OR of (status AND mask).
- R11: A flush command empties the FIFO and restarts channel alternation at channel 0. The configuration and the mask are kept.
- R12: A soft-reset command returns the FIFO, configuration, mask, sticky bits and channel alternation to their R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | REG_AW | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Read strobe (clears sticky bits on status) |
| rd_addr | input | REG_AW | Register read word address |
| rd_data | output | 32 | Combinational read data |
| smp_req | input | 1 | Transmitter sample request |
| smp_vld | output | 1 | Sample returned, one cycle after request |
| smp_data | output | 32 | Left-aligned sample |
| smp_ch | output | 1 | Channel of the returned sample |
| irq | output | 1 | Masked status interrupt |

## Verification
The hardest conditions to reach from the ports are two. The first is a sticky event landing in the same cycle as the status read that clears it. The second is a dual-channel run in which the write and request channel phases have drifted apart through dropped writes and underruns. The bench forces the first directly: it raises the read strobe and a request on an empty FIFO in one cycle. It reaches the second with random mixes of writes, requests and status reads under randomly chosen formats and chunk thresholds. A reference model tracks both channel phases and predicts the whole status word after every operation.

// File: rtl/psp_pkg.sv
package psp_pkg;
   localparam int DATA_W = 32;
   localparam int ST_W   = 13;
   localparam int CFG_W  = 15;

   localparam int A_CMD  = 0;
   localparam int A_CFG  = 1;
   localparam int A_DATA = 2;
   localparam int A_MSET = 3;
   localparam int A_MCLR = 4;
   localparam int A_MASK = 5;
   localparam int A_STAT = 6;

   localparam int S_RDY  = 0;
   localparam int S_EMP  = 1;
   localparam int S_FUL  = 2;
   localparam int S_CHK  = 3;
   localparam int S_UDR  = 4;
   localparam int S_OVF  = 5;
   localparam int S_CRDY = 8;
   localparam int S_CUDR = 11;

   localparam logic [ST_W-1:0] STICKY_BITS = 13'b1_1000_0011_0000;

   typedef struct packed {
      logic       dual;
      logic [3:0] chunk;
      logic       msb;
      logic       big;
      logic [5:0] vbits;
      logic [1:0] bytes_m1;
   } cfg_t;

   localparam cfg_t CFG_RST = '{dual: 1'b0, chunk: 4'd1, msb: 1'b0,
                                big: 1'b0, vbits: 6'd32, bytes_m1: 2'd3};
endpackage

// File: rtl/psp_format.sv
module psp_format
   import psp_pkg::*;
(
   input  logic [DATA_W-1:0] word_i,
   input  logic [1:0]        bytes_m1_i,
   input  logic [5:0]        vbits_i,
   input  logic              big_i,
   input  logic              msb_i,
   output logic [DATA_W-1:0] smp_o
);
   localparam int NB = DATA_W / 8;

   logic [DATA_W-1:0] ordered;
   logic [6:0]        vb_eff;
   logic [6:0]        field_w;
   logic [6:0]        shamt;
   logic [DATA_W-1:0] keep;

   always_comb begin
      ordered = '0;
      for (int i = 0; i < NB; i++) begin
         if (i <= int'(bytes_m1_i)) begin
            if (big_i)
               ordered[8*i +: 8] = word_i[8*(int'(bytes_m1_i) - i) +: 8];
            else
               ordered[8*i +: 8] = word_i[8*i +: 8];
         end
      end
   end

   always_comb begin
      vb_eff  = (vbits_i == 6'd0 || vbits_i > 6'd32) ? 7'd32 : {1'b0, vbits_i};
      field_w = {2'b00, bytes_m1_i, 3'b000} + 7'd8;
      shamt   = msb_i ? (7'(DATA_W) - field_w) : (7'(DATA_W) - vb_eff);
      keep    = ~({DATA_W{1'b1}} >> vb_eff);
      smp_o   = (ordered << shamt) & keep;
   end
endmodule

// File: rtl/psp_fifo.sv
module psp_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 32,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("psp_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp, rp;

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         count <= '0;
      end else begin
         if (push) wp <= AW'(wp + 1'b1);
         if (pop)  rp <= AW'(rp + 1'b1);
         case ({push, pop})
            2'b10:   count <= CW'(count + 1'b1);
            2'b01:   count <= CW'(count - 1'b1);
            default: count <= count;
         endcase
      end
   end

   assign dout = mem[rp];
endmodule

// File: rtl/psp_irq.sv
module psp_irq #(
   parameter int              ST_W   = 13,
   parameter logic [ST_W-1:0] STICKY = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            srst,
   input  logic [ST_W-1:0] live,
   input  logic [ST_W-1:0] ev,
   input  logic            stat_rd,
   input  logic            mask_set,
   input  logic            mask_clr,
   input  logic [ST_W-1:0] mask_val,
   output logic [ST_W-1:0] status,
   output logic [ST_W-1:0] mask,
   output logic            irq
);
   logic [ST_W-1:0] sticky;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sticky <= '0;
         mask   <= '0;
      end else if (srst) begin
         sticky <= '0;
         mask   <= '0;
      end else begin
         sticky <= ((stat_rd ? '0 : sticky) | ev) & STICKY;
         if (mask_set)      mask <= mask | mask_val;
         else if (mask_clr) mask <= mask & ~mask_val;
      end
   end

   assign status = (live & ~STICKY) | sticky;
   assign irq    = |(status & mask);
endmodule

// File: rtl/pcm_sample_packer.sv
module pcm_sample_packer
   import psp_pkg::*;
#(
   parameter int DEPTH  = 8,
   parameter int REG_AW = 3,
   localparam int CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic              rd_en,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic              smp_req,
   output logic              smp_vld,
   output logic [31:0]       smp_data,
   output logic              smp_ch,
   output logic              irq
);
   generate
      if (REG_AW < 3) begin : g_bad_aw
         $error("pcm_sample_packer: REG_AW must be at least 3");
      end
      if (DEPTH > 256) begin : g_bad_depth
         $error("pcm_sample_packer: DEPTH above 256 is not supported");
      end
   endgenerate

   cfg_t              cfg;
   logic              wr_cmd, srst, flush, push_req, push, ovf_evt;
   logic              pop, udr_evt, stat_rd, full, empty;
   logic              wch, rch, serve_ch;
   logic [CW-1:0]     count, free;
   logic [DATA_W-1:0] fmt_word, head;
   logic [ST_W-1:0]   live, ev, st_vec, irq_mask;

   assign wr_cmd   = wr_en && (wr_addr == REG_AW'(A_CMD));
   assign srst     = wr_cmd && wr_data[1];
   assign flush    = wr_cmd && wr_data[0];
   assign push_req = wr_en && (wr_addr == REG_AW'(A_DATA));
   assign push     = push_req && !full;
   assign ovf_evt  = push_req && full;
   assign pop      = smp_req && !empty;
   assign udr_evt  = smp_req && empty;
   assign stat_rd  = rd_en && (rd_addr == REG_AW'(A_STAT));
   assign serve_ch = cfg.dual ? rch : 1'b0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg <= CFG_RST;
      else if (srst)
         cfg <= CFG_RST;
      else if (wr_en && wr_addr == REG_AW'(A_CFG))
         cfg <= wr_data[CFG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wch <= 1'b0;
         rch <= 1'b0;
      end else if (srst || flush) begin
         wch <= 1'b0;
         rch <= 1'b0;
      end else begin
         if (push && cfg.dual)    wch <= !wch;
         if (smp_req && cfg.dual) rch <= !rch;
      end
   end

   psp_format u_fmt (
      .word_i     (wr_data),
      .bytes_m1_i (cfg.bytes_m1),
      .vbits_i    (cfg.vbits),
      .big_i      (cfg.big),
      .msb_i      (cfg.msb),
      .smp_o      (fmt_word)
   );

   psp_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush || srst),
      .push  (push),
      .pop   (pop),
      .din   (fmt_word),
      .dout  (head),
      .count (count)
   );

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign free  = CW'(DEPTH) - count;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         smp_vld  <= 1'b0;
         smp_data <= '0;
         smp_ch   <= 1'b0;
      end else begin
         smp_vld <= smp_req;
         if (smp_req) begin
            smp_data <= empty ? '0 : head;
            smp_ch   <= serve_ch;
         end
      end
   end

   always_comb begin
      live             = '0;
      live[S_RDY]      = !full;
      live[S_EMP]      = empty;
      live[S_FUL]      = full;
      live[S_CHK]      = 32'(free) >= 32'(cfg.chunk);
      live[S_CRDY]     = !full && (cfg.dual ? !wch : 1'b1);
      live[S_CRDY + 1] = !full && cfg.dual && wch;
      ev               = '0;
      ev[S_UDR]        = udr_evt;
      ev[S_OVF]        = ovf_evt;
      ev[S_CUDR]       = udr_evt && !serve_ch;
      ev[S_CUDR + 1]   = udr_evt && serve_ch;
   end

   psp_irq #(.ST_W(ST_W), .STICKY(STICKY_BITS)) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .srst     (srst),
      .live     (live),
      .ev       (ev),
      .stat_rd  (stat_rd),
      .mask_set (wr_en && wr_addr == REG_AW'(A_MSET)),
      .mask_clr (wr_en && wr_addr == REG_AW'(A_MCLR)),
      .mask_val (wr_data[ST_W-1:0]),
      .status   (st_vec),
      .mask     (irq_mask),
      .irq      (irq)
   );

   always_comb begin
      case (rd_addr)
         REG_AW'(A_CFG):  rd_data = 32'(cfg);
         REG_AW'(A_MASK): rd_data = 32'(irq_mask);
         REG_AW'(A_STAT): rd_data = 32'(st_vec);
         default:         rd_data = '0;
      endcase
   end
endmodule

// File: rtl/psp_checker.sv
module psp_checker
   import psp_pkg::*;
#(
   parameter int REG_AW = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic [1:0]        cmd_bits,
   input logic              smp_req,
   input logic              smp_vld,
   input logic [31:0]       smp_data,
   input logic [ST_W-1:0]   status,
   input logic [ST_W-1:0]   mask,
   input logic              irq
);
   logic cmd_wr;
   assign cmd_wr = wr_en && wr_addr == REG_AW'(A_CMD);

   // R3: write on full FIFO sets overflow
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == REG_AW'(A_DATA) && status[S_FUL]) |=> status[S_OVF]);

   // R3: full and empty never together
   assert_full_empty_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !(status[S_FUL] && status[S_EMP]));

   // R4: request on empty gives null sample and underrun flag
   assert_underrun_null_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_req && status[S_EMP] && !(cmd_wr && cmd_bits[1]))
      |=> (smp_vld && smp_data == 32'd0 && status[S_UDR]));

   // R2: one returned sample per request, one cycle later
   assert_req_vld_R2: assert property (@(posedge clk) disable iff (!rst_n)
      smp_req |=> smp_vld);
   assert_noreq_novld_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_req |=> !smp_vld);

   // R11: flush leaves FIFO empty
   assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_bits[0]) |=> status[S_EMP]);

   // R10: no interrupt with an empty mask
   assert_irq_needs_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (mask != '0));
endmodule

bind pcm_sample_packer psp_checker #(.REG_AW(REG_AW)) u_psp_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .cmd_bits (wr_data[1:0]),
   .smp_req  (smp_req),
   .smp_vld  (smp_vld),
   .smp_data (smp_data),
   .status   (st_vec),
   .mask     (irq_mask),
   .irq      (irq)
);

// File: tb/pcm_sample_packer_bench.sv
module pcm_sample_packer_bench;
   localparam int DEPTH  = 8;
   localparam int REG_AW = 3;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              wr_en = 1'b0;
   logic [REG_AW-1:0] wr_addr = '0;
   logic [31:0]       wr_data = '0;
   logic              rd_en = 1'b0;
   logic [REG_AW-1:0] rd_addr = '0;
   logic [31:0]       rd_data;
   logic              smp_req = 1'b0;
   logic              smp_vld;
   logic [31:0]       smp_data;
   logic              smp_ch;
   logic              irq;

   always #10 clk = ~clk;

   pcm_sample_packer #(.DEPTH(DEPTH), .REG_AW(REG_AW)) u_pcm_sample_packer (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .smp_req(smp_req),
      .smp_vld(smp_vld), .smp_data(smp_data), .smp_ch(smp_ch), .irq(irq)
   );

   int total = 0;
   int bad   = 0;

   // reference model state
   logic [31:0] q[$];
   logic [1:0]  m_bm1;
   logic [5:0]  m_vb;
   logic        m_big, m_msb, m_dual;
   logic [3:0]  m_chunk;
   logic        wch, rch, udr, ovf, cu0, cu1;
   logic [12:0] m_mask;

   task automatic chk(string msg, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", msg, act, exp);
      end
   endtask

   function automatic logic [31:0] fmt(logic [31:0] w, logic [1:0] bm1, logic [5:0] vb,
                                       logic big, logic msb);
      int n = int'(bm1) + 1;
      int fw = 8 * n;
      int v = (vb == 0 || vb > 32) ? 32 : int'(vb);
      logic [31:0] s = '0;
      logic [31:0] o = '0;
      for (int k = 0; k < n; k++)
         s[8*k +: 8] = big ? w[8*(n-1-k) +: 8] : w[8*k +: 8];
      for (int k = 0; k < v; k++) begin
         int src = msb ? (fw - v + k) : k;
         if (src >= 0 && src < 32) o[32 - v + k] = s[src];
      end
      return o;
   endfunction

   function automatic logic [31:0] exp_status();
      int n = q.size();
      logic f = (n == DEPTH);
      logic [31:0] s = '0;
      s[0]  = !f;
      s[1]  = (n == 0);
      s[2]  = f;
      s[3]  = (DEPTH - n) >= int'(m_chunk);
      s[4]  = udr;
      s[5]  = ovf;
      s[8]  = !f && (m_dual ? !wch : 1'b1);
      s[9]  = !f && m_dual && wch;
      s[11] = cu0;
      s[12] = cu1;
      return s;
   endfunction

   task automatic model_reset();
      q.delete();
      m_bm1 = 2'd3; m_vb = 6'd32; m_big = 0; m_msb = 0; m_dual = 0; m_chunk = 4'd1;
      wch = 0; rch = 0; udr = 0; ovf = 0; cu0 = 0; cu1 = 0; m_mask = '0;
   endtask

   task automatic do_wr(int addr, logic [31:0] d);
      case (addr)
         0: begin
            if (d[1]) model_reset();
            else if (d[0]) begin q.delete(); wch = 0; rch = 0; end
         end
         1: begin
            m_bm1 = d[1:0]; m_vb = d[7:2]; m_big = d[8]; m_msb = d[9];
            m_chunk = d[13:10]; m_dual = d[14];
         end
         2: begin
            if (q.size() == DEPTH) ovf = 1;
            else begin
               q.push_back(fmt(d, m_bm1, m_vb, m_big, m_msb));
               if (m_dual) wch = !wch;
            end
         end
         3: m_mask = m_mask | d[12:0];
         4: m_mask = m_mask & ~d[12:0];
         default: ;
      endcase
      @(negedge clk);
      wr_en = 1; wr_addr = REG_AW'(addr); wr_data = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   task automatic do_pop(string tag, output logic [31:0] got);
      logic [31:0] e;
      logic ech;
      ech = m_dual ? rch : 1'b0;
      if (q.size() == 0) begin
         e = '0; udr = 1;
         if (ech) cu1 = 1; else cu0 = 1;
      end else e = q.pop_front();
      if (m_dual) rch = !rch;
      @(negedge clk); smp_req = 1;
      @(negedge clk); smp_req = 0;
      got = smp_data;
      chk({tag, " R2 vld"}, 32'(smp_vld), 32'd1);
      chk({tag, " R2 data"}, smp_data, e);
      chk({tag, " R9 ch"}, 32'(smp_ch), 32'(ech));
   endtask

   task automatic peek_status(string tag);
      logic [31:0] es;
      es = exp_status();
      rd_addr = 3'd6; #1;
      chk({tag, " status"}, rd_data, es);
      chk({tag, " R10 irq"}, 32'(irq), 32'(|(es[12:0] & m_mask)));
   endtask

   task automatic read_clear(string tag);
      @(negedge clk);
      rd_en = 1; rd_addr = 3'd6; #1;
      chk({tag, " R5 read"}, rd_data, exp_status());
      @(negedge clk);
      rd_en = 0;
      udr = 0; ovf = 0; cu0 = 0; cu1 = 0;
   endtask

   function automatic logic [31:0] cfg_word(logic [1:0] bm1, logic [5:0] vb, logic big,
                                            logic msb, logic [3:0] ck, logic dual);
      return 32'(bm1) | (32'(vb) << 2) | (32'(big) << 8) | (32'(msb) << 9) |
             (32'(ck) << 10) | (32'(dual) << 14);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog R2: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [31:0] got;
      int vbs[6] = '{8, 16, 18, 20, 24, 32};
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      rd_addr = 3'd6; #1; chk("R1 status", rd_data, 32'h10B);
      rd_addr = 3'd1; #1; chk("R1 cfg", rd_data, 32'h483);
      rd_addr = 3'd5; #1; chk("R1 mask", rd_data, 32'h0);
      chk("R1 irq", 32'(irq), 32'd0);

      // R2 order, default format passes words through
      do_wr(2, 32'h11111111); do_wr(2, 32'h22222222); do_wr(2, 32'h33333333);
      do_pop("order1", got); chk("R2 first", got, 32'h11111111);
      do_pop("order2", got); do_pop("order3", got);
      @(negedge clk); chk("R2 vld single cycle", 32'(smp_vld), 32'd0);

      // R6 big-endian three bytes, 24 valid, LSB
      do_wr(1, cfg_word(2'd2, 6'd24, 1, 0, 4'd1, 0));
      do_wr(2, 32'hAABBCCDD);
      do_pop("R6 be", got); chk("R6 big endian 3 bytes", got, 32'hDDCCBB00);
      // R7 MSB-justified 20 of 32, and LSB 18 of 24
      do_wr(1, cfg_word(2'd3, 6'd20, 0, 1, 4'd1, 0));
      do_wr(2, 32'h12345678);
      do_pop("R7 msb", got); chk("R7 msb 20", got, 32'h12345000);
      do_wr(1, cfg_word(2'd2, 6'd18, 0, 0, 4'd1, 0));
      do_wr(2, 32'hFF3FFFFF);
      do_pop("R7 lsb", got); chk("R7 lsb 18", got, 32'hFFFFC000);

      // R3 overflow
      for (int i = 0; i < DEPTH + 1; i++) do_wr(2, 32'(i));
      peek_status("R3 full+ovf");
      chk("R3 ovf bit", rd_data & 32'h25, 32'h24);
      read_clear("R3");
      peek_status("R5 after clear");

      // R11 flush keeps config
      do_wr(0, 32'h1);
      peek_status("R11 flush");
      rd_addr = 3'd1; #1; chk("R11 cfg kept", rd_data, cfg_word(2'd2, 6'd18, 0, 0, 4'd1, 0));

      // R4 underrun
      do_pop("R4 udr", got);
      peek_status("R4 flags");
      chk("R4 bits", rd_data & 32'h810, 32'h810);

      // R5 event in same cycle as clearing read
      @(negedge clk);
      rd_en = 1; rd_addr = 3'd6; smp_req = 1;
      @(negedge clk);
      rd_en = 0; smp_req = 0;
      udr = 1; ovf = 0; cu0 = 1; cu1 = 0;
      chk("R5 null sample", smp_data, 32'h0);
      peek_status("R5 event wins");

      // R8 chunk threshold 5
      do_wr(0, 32'h1);
      do_wr(1, cfg_word(2'd3, 6'd32, 0, 0, 4'd5, 0));
      do_wr(2, 1); do_wr(2, 2); do_wr(2, 3);
      peek_status("R8 free5"); chk("R8 chunk set", rd_data & 32'h8, 32'h8);
      do_wr(2, 4);
      peek_status("R8 free4"); chk("R8 chunk clear", rd_data & 32'h8, 32'h0);

      // R10 mask
      do_wr(3, 32'h0001);
      peek_status("R10 set"); chk("R10 irq on", 32'(irq), 32'd1);
      do_wr(4, 32'h0001);
      peek_status("R10 clr"); chk("R10 irq off", 32'(irq), 32'd0);

      // R9 dual-channel alternation
      do_wr(0, 32'h1);
      do_wr(1, cfg_word(2'd3, 6'd32, 0, 0, 4'd1, 1));
      peek_status("R9 ch0 next"); chk("R9 ch ready", rd_data & 32'h300, 32'h100);
      do_wr(2, 32'hA);
      peek_status("R9 ch1 next"); chk("R9 ch ready 1", rd_data & 32'h300, 32'h200);
      do_pop("R9 pop0", got); do_pop("R9 pop1", got);
      peek_status("R9 udr ch1");

      // R12 soft reset
      do_wr(3, 32'h1FFF); do_wr(2, 32'h5);
      do_wr(0, 32'h2);
      rd_addr = 3'd6; #1; chk("R12 status", rd_data, 32'h10B);
      rd_addr = 3'd1; #1; chk("R12 cfg", rd_data, 32'h483);
      rd_addr = 3'd5; #1; chk("R12 mask", rd_data, 32'h0);
      chk("R12 irq", 32'(irq), 32'd0);

      // random mix: R2 R3 R4 R6 R7 R8 R9 R10
      for (int c = 0; c < 30; c++) begin
         logic [1:0] bm1;
         int vb;
         bm1 = 2'($urandom_range(0, 3));
         do vb = vbs[$urandom_range(0, 5)]; while (vb > 8 * (int'(bm1) + 1));
         do_wr(1, cfg_word(bm1, 6'(vb), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                           4'($urandom_range(0, 15)), 1'($urandom_range(0, 1))));
         do_wr(0, 32'h1);
         do_wr(3, 32'($urandom_range(0, 8191)));
         do_wr(4, 32'($urandom_range(0, 8191)));
         for (int k = 0; k < 25; k++) begin
            int r = $urandom_range(0, 9);
            if (r < 5) do_wr(2, $urandom());
            else if (r < 9) do_pop("rand R2 R4 R9", got);
            else read_clear("rand");
            peek_status("rand R3 R8 R9");
         end
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule